// File: doc/BRIEF.md
# Instruction Decoder and Program Counter Sequencer

This block sits at the front of a single-cycle 16-bit processor. It looks at the current 16-bit instruction word and turns its five-bit operation code (bits 15 to 11) into the control signals the rest of the core needs. These signals are the source and destination register indices, an ALU operation code, the register write enable and write-back source select, the data memory read and write strobes, and the choice between incrementing the program counter and jumping. Each instruction falls into one of four classes: ALU, jump, memory/constant load or store, and undefined.

The block also holds the program counter. Every cycle the counter does one of three things. It returns to zero while the synchronous reset is high, or it loads the 11-bit target from bits 10 to 0 for a taken jump, or it advances by one. Reset takes priority over the other two. The carry and zero flags come in from outside and only affect the four conditional jumps. The ALU, register storage and memories are outside this block.

Top module: `insn_seq`

## Requirements
- R1: Opcodes 4 to 19 are ALU instructions: class 1, `reg_we`=1, `wb_sel`=0 (ALU result), `alu_op` = opcode − 4 (opcode 7 is ADD, giving `alu_op`=3), with no memory strobe and `pc_inc`=1.
- R2: The register fields are always driven from fixed positions: `rd` from bits 10:8, `rs1` from bits 5:3, `rs2` from bits 2:0, and `imm8` from bits 7:0.
- R3: Opcode 1 (memory load) gives class 3, `mem_rd`=1, `reg_we`=1, `wb_sel`=1 (memory data) and `pc_inc`=1.
- R4: Opcode 2 (memory store) gives class 3, `mem_wr`=1, `reg_we`=0, `mem_rd`=0 and `pc_inc`=1. The two memory strobes are never high together.
- R5: Opcodes 25 and 26 load a constant into the low byte or the high byte of the destination: class 3, `reg_we`=1, `wb_sel`=2 or 3 respectively, `pc_inc`=1.
- R6: Opcode 20 is an unconditional jump. It gives `pc_inc`=0, and on the next edge `pc` equals bits 10:0 of the instruction.
- R7: Opcodes 21, 22, 23 and 24 jump when, respectively, carry is 1, zero is 1, carry is 0, or zero is 0. When the condition is false, `pc_inc`=1 and the PC advances by one.
- R8: Opcodes 0, 3 and 27 to 31 are undefined. They give class 0, no register or memory write, and `pc_inc`=1.
- R9: While `rst`=1 the next PC is 0, even when a jump is taken.
- R10: Incrementing wraps from 2047 to 0.
- R11: Jump instructions (class 2) never assert `reg_we`, `mem_rd` or `mem_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instr | input | 16 | Current instruction word |
| carry_in | input | 1 | Carry flag from the ALU |
| zero_in | input | 1 | Zero flag from the ALU |
| pc | output | 11 | Program counter (instruction address) |
| cls | output | 2 | Class: 0 undefined, 1 ALU, 2 jump, 3 memory/constant |
| rd | output | 3 | Destination register index |
| rs1 | output | 3 | First source / address register index |
| rs2 | output | 3 | Second source / store data register index |
| alu_op | output | 4 | ALU operation code |
| imm8 | output | 8 | Constant byte |
| reg_we | output | 1 | Register write enable |
| wb_sel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 constant low, 3 constant high |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| pc_inc | output | 1 | 1 = increment PC, 0 = load jump target |

## Verification
The PC properties assume that `instr` and the flags are stable around each rising edge and that the PC is sampled only on cycles that follow a reset-free cycle. The stimulus changes inputs only on falling edges and holds `rst` for whole cycles. The decode properties assume nothing about the inputs, because every 5-bit opcode maps to a defined class. The vector table covers every class with both flag values for each conditional jump. Directed cases then cover reset against a taken jump and the 2047-to-0 wrap.

// File: rtl/insn_seq.sv
module insn_seq #(
  parameter int PC_W = 11
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     instr,
  input  logic            carry_in,
  input  logic            zero_in,
  output logic [PC_W-1:0] pc,
  output logic [1:0]      cls,
  output logic [2:0]      rd,
  output logic [2:0]      rs1,
  output logic [2:0]      rs2,
  output logic [3:0]      alu_op,
  output logic [7:0]      imm8,
  output logic            reg_we,
  output logic [1:0]      wb_sel,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            pc_inc
);

  localparam logic [1:0] C_NONE = 2'd0, C_ALU = 2'd1, C_JMP = 2'd2, C_MEM = 2'd3;
  localparam logic [PC_W-1:0] PC_ONE = {{(PC_W-1){1'b0}}, 1'b1};

  logic [4:0]      op;
  logic [PC_W-1:0] target;
  logic            take;

  assign op     = instr[15:11];
  assign rd     = instr[10:8];
  assign rs1    = instr[5:3];
  assign rs2    = instr[2:0];
  assign imm8   = instr[7:0];
  assign target = instr[PC_W-1:0];
  assign pc_inc = !take;

  always_comb begin
    cls    = C_NONE;
    alu_op = 4'd0;
    reg_we = 1'b0;
    wb_sel = 2'd0;
    mem_rd = 1'b0;
    mem_wr = 1'b0;
    take   = 1'b0;
    if (op >= 5'd4 && op <= 5'd19) begin
      cls    = C_ALU;
      reg_we = 1'b1;
      alu_op = op[3:0] - 4'd4;
    end else begin
      case (op)
        5'd1:  begin cls = C_MEM; mem_rd = 1'b1; reg_we = 1'b1; wb_sel = 2'd1; end
        5'd2:  begin cls = C_MEM; mem_wr = 1'b1; end
        5'd25: begin cls = C_MEM; reg_we = 1'b1; wb_sel = 2'd2; end
        5'd26: begin cls = C_MEM; reg_we = 1'b1; wb_sel = 2'd3; end
        5'd20: begin cls = C_JMP; take = 1'b1; end
        5'd21: begin cls = C_JMP; take = carry_in; end
        5'd22: begin cls = C_JMP; take = zero_in; end
        5'd23: begin cls = C_JMP; take = !carry_in; end
        5'd24: begin cls = C_JMP; take = !zero_in; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (take) pc <= target;
    else           pc <= pc + PC_ONE;
  end

  a_r9_reset_zero: assert property (@(posedge clk) rst |=> pc == '0);
  a_r6_jump_load: assert property (@(posedge clk) disable iff (rst)
    !pc_inc |=> pc == $past(instr[PC_W-1:0]));
  a_r10_increment: assert property (@(posedge clk) disable iff (rst)
    pc_inc |=> pc == $past(pc) + PC_ONE);
  a_r4_strobes: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_rd, mem_wr}) && !(mem_wr && reg_we));
  a_r8_undefined_quiet: assert property (@(posedge clk) disable iff (rst)
    cls == C_NONE |-> !reg_we && !mem_rd && !mem_wr && pc_inc);
  a_r11_jump_quiet: assert property (@(posedge clk) disable iff (rst)
    cls == C_JMP |-> !reg_we && !mem_rd && !mem_wr);

endmodule

// File: tb/insn_seq_test.sv
module insn_seq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr = 16'h0000;
  logic        carry_in = 1'b0, zero_in = 1'b0;
  logic [10:0] pc;
  logic [1:0]  cls, wb_sel;
  logic [2:0]  rd, rs1, rs2;
  logic [3:0]  alu_op;
  logic [7:0]  imm8;
  logic        reg_we, mem_rd, mem_wr, pc_inc;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  insn_seq uut (.clk(clk), .rst(rst), .instr(instr), .carry_in(carry_in), .zero_in(zero_in),
    .pc(pc), .cls(cls), .rd(rd), .rs1(rs1), .rs2(rs2), .alu_op(alu_op), .imm8(imm8),
    .reg_we(reg_we), .wb_sel(wb_sel), .mem_rd(mem_rd), .mem_wr(mem_wr), .pc_inc(pc_inc));

  // ins, carry, zero, cls, we, rd, wr, wb, inc, alu
  localparam int NV = 21;
  localparam logic [29:0] VEC [NV] = '{
    {5'd7,  11'h123, 2'b00, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd3},
    {5'd4,  11'h0FF, 2'b11, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd19, 11'h7FF, 2'b00, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd15},
    {5'd12, 11'h055, 2'b10, 2'd1, 1'b1, 1'b0, 1'b0, 2'd0, 1'b1, 4'd8},
    {5'd1,  11'h321, 2'b00, 2'd3, 1'b1, 1'b1, 1'b0, 2'd1, 1'b1, 4'd0},
    {5'd2,  11'h00A, 2'b00, 2'd3, 1'b0, 1'b0, 1'b1, 2'd0, 1'b1, 4'd0},
    {5'd25, 11'h4AB, 2'b00, 2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 4'd0},
    {5'd26, 11'h2CD, 2'b00, 2'd3, 1'b1, 1'b0, 1'b0, 2'd3, 1'b1, 4'd0},
    {5'd20, 11'h100, 2'b00, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0},
    {5'd21, 11'h200, 2'b10, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0},
    {5'd21, 11'h300, 2'b01, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd22, 11'h010, 2'b01, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0},
    {5'd22, 11'h020, 2'b10, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd23, 11'h030, 2'b01, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0},
    {5'd23, 11'h040, 2'b10, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd24, 11'h050, 2'b10, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 4'd0},
    {5'd24, 11'h060, 2'b01, 2'd2, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd0,  11'h3FF, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd3,  11'h111, 2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd31, 11'h7FF, 2'b00, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0},
    {5'd27, 11'h222, 2'b11, 2'd0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 4'd0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd1: return "R1";
      2'd2: return "R7";
      2'd3: return "R3/R4/R5";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [10:0] pc_before;
    logic [10:0] exp_pc;
    repeat (2) @(posedge clk);
    #1 check("R9 reset pc", 32'(pc), 32'd0);
    @(negedge clk) rst = 1'b0;

    for (int n = 0; n < NV; n++) begin
      @(negedge clk);
      instr = VEC[n][29:14]; carry_in = VEC[n][13]; zero_in = VEC[n][12];
      pc_before = pc;
      #1;
      check(tag_of(VEC[n][11:10]), {20'd0, cls, reg_we, mem_rd, mem_wr, wb_sel, pc_inc, alu_op},
            {20'd0, VEC[n][11:0]});
      exp_pc = VEC[n][4] ? pc_before + 11'd1 : VEC[n][24:14];
      @(posedge clk); #1;
      check(VEC[n][4] ? "R7/R10 next pc" : "R6/R7 next pc", 32'(pc), 32'(exp_pc));
    end

    // R11: jump decode drives no writes
    @(negedge clk); instr = {5'd20, 11'h5A5}; #1;
    check("R11 jump quiet", {29'd0, reg_we, mem_rd, mem_wr}, 32'd0);

    // R2: field positions
    @(negedge clk); instr = {5'd7, 3'd5, 2'b10, 3'd2, 3'd6}; #1;
    check("R2 fields", {15'd0, rd, rs1, rs2, imm8}, {15'd0, 3'd5, 3'd2, 3'd6, 8'b10010110});

    // R9: reset outranks a taken jump
    @(negedge clk); instr = {5'd20, 11'h345}; rst = 1'b1;
    @(posedge clk); #1 check("R9 reset over jump", 32'(pc), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R10: wrap 2047 -> 0
    instr = {5'd20, 11'h7FF};
    @(posedge clk); #1 check("R6 jump to 2047", 32'(pc), 32'h7FF);
    @(negedge clk); instr = {5'd7, 11'h000};
    @(posedge clk); #1 check("R10 wrap", 32'(pc), 32'd0);
    @(posedge clk); #1 check("R10 step after wrap", 32'(pc), 32'd1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule